// File: doc/BRIEF.md
# Work Completion Message Builder

This block turns one per-module completion record into a short stream of 128-bit beats for a host-facing mailbox. A record carries a request handle, a module number, an all-arrived flag, a trigger flag, a frame number, a debug word, a low timestamp, a bunch identifier and a 128-bit per-packet arrival mask.

When every packet of the module arrived, the message is two beats long. When any packet is missing, a third beat carrying the arrival mask follows. The first beat carries a parity bit chosen so that the whole beat has even parity. Records are taken through a valid/ready handshake only while the builder is idle. Beats leave through a second valid/ready handshake with a last marker on the final beat.

Top module: `wc_msg_builder`

## Requirements
- R1: After reset, and whenever no message is in flight, `rec_ready_o` is 1 and `beat_valid_o` is 0. While a message is in flight, `rec_ready_o` is 0.
- R2: Beat 0 layout: bits [31:0] handle, [39:32] module number, bit 40 all-arrived flag, bit 41 trigger flag, bits [62:42] zero, bits [127:64] frame number.
- R3: Bit 63 of beat 0 is set exactly when needed to make the XOR of all 128 bits of beat 0 equal to 0.
- R4: Beat 1 layout: bits [31:0] debug word, [63:32] low timestamp, [127:64] bunch identifier.
- R5: With the all-arrived flag at 1, the message is exactly two beats and `beat_last_o` is 1 on beat 1 only.
- R6: With the all-arrived flag at 0, the message is exactly three beats, beat 2 equals the arrival mask (bit i = 1 means packet i arrived), and `beat_last_o` is 1 on beat 2 only.
- R7: While `beat_valid_o` is 1 and `beat_ready_i` is 0, the beat data and last marker stay unchanged and valid stays 1.
- R8: A record presented while a message is in flight is not taken and does not change the beats of that message.
- R9: In the cycle after the last beat is taken, `beat_valid_o` is 0 and `rec_ready_o` is 1, so a new record can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record present |
| rec_ready_o | output | 1 | Builder idle, record taken on valid and ready |
| handle_i | input | 32 | Request handle |
| module_i | input | 8 | Module number |
| all_ok_i | input | 1 | All packets of the module arrived |
| trigger_i | input | 1 | Trigger flag |
| frame_i | input | 64 | Frame number |
| debug_i | input | 32 | Debug word |
| tstamp_i | input | 32 | Low timestamp |
| bunch_i | input | 64 | Bunch identifier |
| mask_i | input | 128 | Per-packet arrival mask |
| beat_valid_o | output | 1 | Output beat valid |
| beat_ready_i | input | 1 | Consumer takes the beat |
| beat_data_o | output | 128 | Output beat |
| beat_last_o | output | 1 | Final beat of the message |

## Verification
The assertions watch every cycle for even parity and the zero gap on beat 0, for the last marker landing on beat 1 or beat 2 according to the flag carried in beat 0, for beats held still under back-pressure, and for the builder returning to idle right after the last beat. Field placement against the inputs, the mask contents and the fact that a record offered mid-message is left untaken can only be shown by the bench, which compares whole messages against its own expected beats under random and all-ones back-pressure.

// File: rtl/wc_msg_pkg.sv
package wc_msg_pkg;
  localparam int unsigned BEAT_W   = 128;
  localparam int unsigned MAX_BEAT = 3;
  localparam int unsigned IDX_W    = $clog2(MAX_BEAT);
  localparam int unsigned HDL_W    = 32;
  localparam int unsigned MOD_W    = 8;
  localparam int unsigned FRM_W    = 64;
  localparam int unsigned DBG_W    = 32;
  localparam int unsigned TS_W     = 32;
  localparam int unsigned BUN_W    = 64;
  localparam int unsigned PAR_BIT  = 63;
  localparam int unsigned GAP_W    = PAR_BIT - (HDL_W + MOD_W + 2);

  typedef struct packed {
    logic [BUN_W-1:0]  bunch;
    logic [TS_W-1:0]   tstamp;
    logic [DBG_W-1:0]  debug;
    logic [FRM_W-1:0]  frame;
    logic              trigger;
    logic              all_ok;
    logic [MOD_W-1:0]  module_no;
    logic [HDL_W-1:0]  handle;
    logic [BEAT_W-1:0] mask;
  } rec_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} seq_st_e;
endpackage

// File: rtl/wc_parity.sv
module wc_parity #(
  parameter int unsigned W = 128
) (
  input  logic [W-1:0] data_i,
  output logic         odd_o
);
  localparam int unsigned LVL = $clog2(W);
  localparam int unsigned PW  = 1 << LVL;

  logic [2*PW-2:0] tree;

  // leaves at [PW-1 +: PW], root at [0]
  for (genvar i = 0; i < PW; i++) begin : g_leaf
    if (i < W) begin : g_in
      assign tree[PW-1+i] = data_i[i];
    end else begin : g_pad
      assign tree[PW-1+i] = 1'b0;
    end
  end

  for (genvar n = 0; n < PW-1; n++) begin : g_node
    assign tree[n] = tree[2*n+1] ^ tree[2*n+2];
  end

  assign odd_o = tree[0];
endmodule

// File: rtl/wc_beat_format.sv
module wc_beat_format
  import wc_msg_pkg::*;
(
  input  rec_t                    rec_i,
  output logic [MAX_BEAT-1:0][BEAT_W-1:0] beats_o
);
  logic [BEAT_W-1:0] head_raw;
  logic              head_odd;

  assign head_raw = {rec_i.frame, 1'b0, {GAP_W{1'b0}}, rec_i.trigger,
                     rec_i.all_ok, rec_i.module_no, rec_i.handle};

  wc_parity #(.W(BEAT_W)) i_par (
    .data_i (head_raw),
    .odd_o  (head_odd)
  );

  always_comb begin
    beats_o          = '0;
    beats_o[0]       = head_raw;
    beats_o[0][PAR_BIT] = head_odd;
    beats_o[1]       = {rec_i.bunch, rec_i.tstamp, rec_i.debug};
    beats_o[2]       = rec_i.mask;
  end
endmodule

// File: rtl/wc_beat_seq.sv
module wc_beat_seq
  import wc_msg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             all_ok_i,
  input  logic             out_ready_i,
  output logic             idle_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic [IDX_W-1:0] idx_o
);
  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] end_q;
  logic             fire;

  assign idle_o      = (st_q == ST_IDLE);
  assign out_valid_o = (st_q == ST_SEND);
  assign out_last_o  = out_valid_o && (idx_q == end_q);
  assign idx_o       = idx_q;
  assign fire        = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      end_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (take_i) begin
        st_q  <= ST_SEND;
        idx_q <= '0;
        end_q <= all_ok_i ? IDX_W'(MAX_BEAT-2) : IDX_W'(MAX_BEAT-1);
      end
    end else if (fire) begin
      if (out_last_o) begin
        st_q  <= ST_IDLE;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wc_msg_builder.sv
module wc_msg_builder
  import wc_msg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  output logic              rec_ready_o,
  input  logic [31:0]       handle_i,
  input  logic [7:0]        module_i,
  input  logic              all_ok_i,
  input  logic              trigger_i,
  input  logic [63:0]       frame_i,
  input  logic [31:0]       debug_i,
  input  logic [31:0]       tstamp_i,
  input  logic [63:0]       bunch_i,
  input  logic [127:0]      mask_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [127:0]      beat_data_o,
  output logic              beat_last_o
);
  rec_t                            rec;
  logic [MAX_BEAT-1:0][BEAT_W-1:0] beats_d;
  logic [BEAT_W-1:0]               beats_q [MAX_BEAT];
  logic [IDX_W-1:0]                idx;
  logic                            idle;
  logic                            take;

  assign rec = '{bunch: bunch_i, tstamp: tstamp_i, debug: debug_i,
                 frame: frame_i, trigger: trigger_i, all_ok: all_ok_i,
                 module_no: module_i, handle: handle_i, mask: mask_i};

  assign take        = rec_valid_i && idle;
  assign rec_ready_o = idle;

  wc_beat_format i_fmt (
    .rec_i   (rec),
    .beats_o (beats_d)
  );

  wc_beat_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .all_ok_i    (all_ok_i),
    .out_ready_i (beat_ready_i),
    .idle_o      (idle),
    .out_valid_o (beat_valid_o),
    .out_last_o  (beat_last_o),
    .idx_o       (idx)
  );

  for (genvar b = 0; b < MAX_BEAT; b++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   beats_q[b] <= '0;
      else if (take) beats_q[b] <= beats_d[b];
    end
  end

  assign beat_data_o = (int'(idx) < MAX_BEAT) ? beats_q[idx] : '0;
endmodule

// File: rtl/wc_msg_builder_chk.sv
module wc_msg_builder_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rec_valid_i,
  input logic         rec_ready_o,
  input logic [31:0]  handle_i,
  input logic [7:0]   module_i,
  input logic         all_ok_i,
  input logic         trigger_i,
  input logic [63:0]  frame_i,
  input logic [31:0]  debug_i,
  input logic [31:0]  tstamp_i,
  input logic [63:0]  bunch_i,
  input logic [127:0] mask_i,
  input logic         beat_valid_o,
  input logic         beat_ready_i,
  input logic [127:0] beat_data_o,
  input logic         beat_last_o
);
  logic [1:0] cnt_q;
  logic       ok_q;
  logic       hs;

  assign hs = beat_valid_o && beat_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (hs) begin
      if (cnt_q == 2'd0) ok_q <= beat_data_o[40];
      cnt_q <= beat_last_o ? 2'd0 : cnt_q + 2'd1;
    end
  end

  a_r1_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o |-> !beat_valid_o);
  a_r1_take_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && rec_ready_o |=> beat_valid_o && !rec_ready_o);
  a_r2_zero_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && cnt_q == 2'd0 |-> beat_data_o[62:42] == '0);
  a_r3_even_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && cnt_q == 2'd0 |-> (^beat_data_o) == 1'b0);
  a_r5_two_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && cnt_q == 2'd1 && ok_q |-> beat_last_o);
  a_r6_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && cnt_q == 2'd1 && !ok_q |-> !beat_last_o);
  a_r6_third_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && cnt_q == 2'd2 |-> beat_last_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=>
      beat_valid_o && $stable(beat_data_o) && $stable(beat_last_o));
  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && beat_last_o |=> rec_ready_o && !beat_valid_o);
endmodule

bind wc_msg_builder wc_msg_builder_chk i_chk (.*);

// File: tb/test_wc_msg_builder.sv
module test_wc_msg_builder;
  import wc_msg_pkg::*;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rec_valid_i = 1'b0;
  logic         rec_ready_o;
  logic [31:0]  handle_i = '0;
  logic [7:0]   module_i = '0;
  logic         all_ok_i = 1'b0;
  logic         trigger_i = 1'b0;
  logic [63:0]  frame_i = '0;
  logic [31:0]  debug_i = '0;
  logic [31:0]  tstamp_i = '0;
  logic [63:0]  bunch_i = '0;
  logic [127:0] mask_i = '0;
  logic         beat_valid_o;
  logic         beat_ready_i = 1'b0;
  logic [127:0] beat_data_o;
  logic         beat_last_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #5ns clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  wc_msg_builder i_wc_msg_builder (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_beat(input rec_t r, input int i);
    logic [127:0] b;
    case (i)
      0: begin
        b = {r.frame, 1'b0, 21'b0, r.trigger, r.all_ok, r.module_no, r.handle};
        b[63] = ^b;
      end
      1: b = {r.bunch, r.tstamp, r.debug};
      default: b = r.mask;
    endcase
    return b;
  endfunction

  function automatic rec_t rand_rec();
    rec_t r;
    r.handle    = $urandom;
    r.module_no = 8'($urandom);
    r.all_ok    = 1'($urandom);
    r.trigger   = 1'($urandom);
    r.frame     = {$urandom, $urandom};
    r.debug     = $urandom;
    r.tstamp    = $urandom;
    r.bunch     = {$urandom, $urandom};
    r.mask      = {$urandom, $urandom, $urandom, $urandom};
    return r;
  endfunction

  task automatic put_rec(input rec_t r);
    handle_i = r.handle; module_i = r.module_no; all_ok_i = r.all_ok;
    trigger_i = r.trigger; frame_i = r.frame; debug_i = r.debug;
    tstamp_i = r.tstamp; bunch_i = r.bunch; mask_i = r.mask;
  endtask

  // one message: drive record, collect beats under back-pressure, compare
  task automatic run_msg(input rec_t r, input int rdy_pct, input bit junk);
    logic [127:0] got [4];
    logic         lst [4];
    int           n = 0;
    bit           done = 0;
    fork
      begin
        @(negedge clk_i);
        while (!rec_ready_o && cyc < 100000) @(negedge clk_i);
        put_rec(r);
        rec_valid_i = 1'b1;
        @(negedge clk_i);
        if (junk) begin
          // R8: a different record offered while busy
          put_rec(rand_rec());
          all_ok_i = ~r.all_ok;
          while (!done && cyc < 100000) @(negedge clk_i);
        end
        rec_valid_i = 1'b0;
      end
      begin
        bit           hold = 0;
        logic [127:0] pd = '0;
        logic         pl = 1'b0;
        while (!done && cyc < 100000) begin
          @(negedge clk_i);
          if (hold) begin
            check("R7 valid held", {127'b0, beat_valid_o}, 128'd1);
            check("R7 data held", beat_data_o, pd);
            check("R7 last held", {127'b0, beat_last_o}, {127'b0, pl});
          end
          beat_ready_i = (int'($urandom_range(99)) < rdy_pct);
          hold = beat_valid_o && !beat_ready_i;
          pd = beat_data_o; pl = beat_last_o;
          if (beat_valid_o) begin
            check("R1 busy not ready", {127'b0, rec_ready_o}, 128'd0);
            if (beat_ready_i) begin
              if (n < 4) begin got[n] = beat_data_o; lst[n] = beat_last_o; end
              n++;
              if (beat_last_o || n >= 4) done = 1;
            end
          end
        end
        @(negedge clk_i);
        beat_ready_i = 1'b0;
        check("R9 valid low after last", {127'b0, beat_valid_o}, 128'd0);
        check("R9 ready after last", {127'b0, rec_ready_o}, 128'd1);
      end
    join
    if (r.all_ok) begin
      check("R5 beat count", 128'(n), 128'd2);
    end else begin
      check("R6 beat count", 128'(n), 128'd3);
    end
    for (int i = 0; i < n && i < 4; i++) begin
      case (i)
        0: begin
          check("R2 beat0", got[0], exp_beat(r, 0));
          check("R3 parity", {127'b0, ^got[0]}, 128'd0);
          check("R5 R6 last beat0", {127'b0, lst[0]}, 128'd0);
        end
        1: begin
          check("R4 beat1", got[1], exp_beat(r, 1));
          check(r.all_ok ? "R5 last beat1" : "R6 last beat1",
                {127'b0, lst[1]}, {127'b0, r.all_ok});
        end
        2: begin
          check("R6 mask beat", got[2], exp_beat(r, 2));
          check("R6 last beat2", {127'b0, lst[2]}, 128'd1);
        end
        default: check("R6 extra beat", 128'd1, 128'd0);
      endcase
    end
  endtask

  initial begin
    rec_t r;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", {127'b0, beat_valid_o}, 128'd0);
    check("R1 reset ready", {127'b0, rec_ready_o}, 128'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    r = rand_rec(); r.all_ok = 1'b1;
    run_msg(r, 100, 0);
    r = rand_rec(); r.all_ok = 1'b0; r.mask = '0;
    run_msg(r, 100, 0);
    r = rand_rec(); r.all_ok = 1'b0; r.mask = '1; r.handle = '1; r.frame = '1;
    run_msg(r, 40, 0);
    r = '0; r.all_ok = 1'b1;
    run_msg(r, 50, 0);
    r = rand_rec(); r.all_ok = 1'b1; r.module_no = 8'hff; r.trigger = 1'b1;
    run_msg(r, 30, 1);
    r = rand_rec(); r.all_ok = 1'b0;
    run_msg(r, 30, 1);

    for (int k = 0; k < 200; k++) begin
      r = rand_rec();
      run_msg(r, int'($urandom_range(100, 20)), 1'($urandom_range(3) == 0));
      if (cyc >= 100000) break;
    end

    if (cyc >= 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #2ms;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule